// File: doc/BRIEF.md
# Transfer Descriptor Completion Tracker

This block follows one general-purpose transfer descriptor while a host controller services it. On a load strobe it captures the descriptor's 32-bit control word and the endpoint's stored toggle carry. From these it presents the data toggle for the next transaction. It then consumes one outcome event per transaction. An event reports a good packet, a transmission error or a short packet. Each event updates the error count, the toggle field and the condition code held inside the control word.

When the descriptor retires, the block pulses a done strobe and presents the rewritten control word and the toggle value the endpoint should keep. On the same cycle it may also pulse an endpoint-halt strobe or an interrupt request. The interrupt request carries the frame delay. The surrounding engine writes the word back and uses the toggle. It does not move data, does not advance buffer pointers and does not count out the interrupt delay.

Top module: `td_completion_tracker`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `doneValid`, `haltOut` and `irqReq` are 0.
- R2: A `load` is taken only when `busy` is 0 and `haltIn` is 0. The block then shows `busy`=1 on the next cycle. A load with `haltIn`=1 leaves `busy` at 0 and `ctlWordOut` unchanged.
- R3: Toggle field is bits 25:24. If bit 25 is 1, `dataToggle` equals bit 24. If bit 25 is 0, `dataToggle` equals the `carryIn` value captured at load.
- R4: Event kind 00 means good packet. It inverts `dataToggle`, writes bit 25 = 1 and bit 24 = the new toggle, and `carryOut` follows the new toggle. With `evtLast`=1 the descriptor retires cleanly.
- R5: Event kind 01 means transmission error. It adds one to the error count in bits 27:26. When the count reaches three (counting a preloaded value), the block retires with condition code (bits 31:28) 0001 and pulses `haltOut`. The toggle is unchanged.
- R6: A clean retire writes error count 00 and condition code 0000.
- R7: Event kind 10 means short packet. It inverts the toggle as in R4 and retires. With bit 18 = 1 the retire is clean. With bit 18 = 0 the block writes condition code 1001, leaves the error count as it was, and halts.
- R8: PID field (bits 20:19) value 11 is reserved. A descriptor holding it retires on the cycle after load, with condition code 0111 and `haltOut`, without waiting for an event.
- R9: `doneValid` lasts exactly one cycle per retire. `haltOut` is high only together with `doneValid`. `irqReq` is high only on a clean retire whose delay field (bits 23:21) is not 111. `irqDelay` shows that field.
- R10: Several inputs have no effect: events while `busy` is 0, event kind 11, and bits 17:0 of the word. Bits 17:0 come out exactly as loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture a new descriptor |
| ctlWordIn | input | 32 | Descriptor control word to capture |
| carryIn | input | 1 | Endpoint toggle carry at load |
| haltIn | input | 1 | Endpoint is halted; blocks load |
| evtValid | input | 1 | Transaction outcome present |
| evtKind | input | 2 | 00 good, 01 error, 10 short, 11 none |
| evtLast | input | 1 | Good packet ends the descriptor |
| busy | output | 1 | Descriptor under service |
| pidOut | output | 2 | PID/direction field of the held word |
| dataToggle | output | 1 | Toggle for the next transaction |
| doneValid | output | 1 | One-cycle retire strobe |
| haltOut | output | 1 | Endpoint must be halted (with done) |
| ctlWordOut | output | 32 | Updated control word |
| carryOut | output | 1 | Toggle carry to store in the endpoint |
| irqReq | output | 1 | Completion interrupt wanted |
| irqDelay | output | 3 | Frame delay for that interrupt |

## Verification
Some properties are checked on every clock: the done strobe lasts a single cycle, halt and interrupt appear only with it, a good packet always flips the carried toggle, an accepted load raises busy, and a reserved PID retires at once with its code and a halt. Other behaviour can only be shown by the bench's scenarios, because it needs whole descriptor histories: the exact field contents of the written-back word, the three-strike count including a preloaded count, the short-packet outcome under each rounding setting, and the refusal of loads and idle events.

// File: rtl/td_pkg.sv
package td_pkg;

  typedef enum logic [1:0] {
    EVT_GOOD  = 2'b00,
    EVT_XERR  = 2'b01,
    EVT_SHORT = 2'b10,
    EVT_NONE  = 2'b11
  } evt_kind_e;

  localparam int RND_BIT  = 18;
  localparam int PID_LO   = 19;
  localparam int DLY_LO   = 21;
  localparam int TOG_VAL  = 24;
  localparam int TOG_SRC  = 25;
  localparam int ERR_LO   = 26;
  localparam int CC_LO    = 28;

  localparam logic [1:0] PID_RSVD = 2'b11;
  localparam logic [3:0] CC_CLEAN = 4'h0;

  typedef struct packed {
    logic       capture;
    logic       flipTog;
    logic       bumpErr;
    logic       clearErr;
    logic       setCc;
    logic [3:0] ccVal;
  } td_strobe_t;

endpackage

// File: rtl/td_data.sv
module td_data
  import td_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  td_strobe_t  stb,
  input  logic [31:0] ctlWordIn,
  input  logic        carryIn,
  output logic [31:0] word,
  output logic        curToggle,
  output logic [1:0]  errCount,
  output logic        rounding,
  output logic [1:0]  pid
);

  logic carryQ;
  logic newToggle;

  assign curToggle = word[TOG_SRC] ? word[TOG_VAL] : carryQ;
  assign newToggle = ~curToggle;
  assign errCount  = word[ERR_LO+1:ERR_LO];
  assign rounding  = word[RND_BIT];
  assign pid       = word[PID_LO+1:PID_LO];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      word   <= '0;
      carryQ <= 1'b0;
    end else if (stb.capture) begin
      word   <= ctlWordIn;
      carryQ <= carryIn;
    end else begin
      if (stb.flipTog) begin
        word[TOG_SRC] <= 1'b1;
        word[TOG_VAL] <= newToggle;
        carryQ        <= newToggle;
      end
      if (stb.clearErr)
        word[ERR_LO+1:ERR_LO] <= 2'b00;
      else if (stb.bumpErr)
        word[ERR_LO+1:ERR_LO] <= errCount + 2'd1;
      if (stb.setCc)
        word[CC_LO+3:CC_LO] <= stb.ccVal;
    end
  end

endmodule

// File: rtl/td_ctrl.sv
module td_ctrl
  import td_pkg::*;
#(
  parameter int         ERR_LIMIT   = 3,
  parameter logic [3:0] CC_XACT_ERR = 4'h1,
  parameter logic [3:0] CC_UNDERRUN = 4'h9,
  parameter logic [3:0] CC_BAD_PID  = 4'h7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       load,
  input  logic       haltIn,
  input  logic       evtValid,
  input  logic [1:0] evtKind,
  input  logic       evtLast,
  input  logic [1:0] errCount,
  input  logic       rounding,
  input  logic [1:0] pid,
  output td_strobe_t stb,
  output logic       busy,
  output logic       doneValid,
  output logic       haltOut
);

  localparam logic [2:0] LIMIT = 3'(ERR_LIMIT);

  logic       retire;
  logic       haltNext;
  logic [2:0] errNext;

  assign errNext = {1'b0, errCount} + 3'd1;

  always_comb begin
    stb      = '0;
    retire   = 1'b0;
    haltNext = 1'b0;
    if (!busy) begin
      stb.capture = load & ~haltIn;
    end else if (pid == PID_RSVD) begin
      retire    = 1'b1;
      haltNext  = 1'b1;
      stb.setCc = 1'b1;
      stb.ccVal = CC_BAD_PID;
    end else if (evtValid) begin
      unique case (evt_kind_e'(evtKind))
        EVT_GOOD: begin
          stb.flipTog = 1'b1;
          if (evtLast) begin
            retire       = 1'b1;
            stb.clearErr = 1'b1;
            stb.setCc    = 1'b1;
            stb.ccVal    = CC_CLEAN;
          end
        end
        EVT_XERR: begin
          stb.bumpErr = 1'b1;
          if (errNext >= LIMIT) begin
            retire    = 1'b1;
            haltNext  = 1'b1;
            stb.setCc = 1'b1;
            stb.ccVal = CC_XACT_ERR;
          end
        end
        EVT_SHORT: begin
          stb.flipTog = 1'b1;
          retire      = 1'b1;
          stb.setCc   = 1'b1;
          if (rounding) begin
            stb.clearErr = 1'b1;
            stb.ccVal    = CC_CLEAN;
          end else begin
            haltNext  = 1'b1;
            stb.ccVal = CC_UNDERRUN;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      doneValid <= 1'b0;
      haltOut   <= 1'b0;
    end else begin
      doneValid <= retire;
      haltOut   <= haltNext;
      if (stb.capture)
        busy <= 1'b1;
      else if (retire)
        busy <= 1'b0;
    end
  end

endmodule

// File: rtl/td_completion_tracker.sv
module td_completion_tracker
  import td_pkg::*;
#(
  parameter int         ERR_LIMIT   = 3,
  parameter logic [3:0] CC_XACT_ERR = 4'h1,
  parameter logic [3:0] CC_UNDERRUN = 4'h9,
  parameter logic [3:0] CC_BAD_PID  = 4'h7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        load,
  input  logic [31:0] ctlWordIn,
  input  logic        carryIn,
  input  logic        haltIn,
  input  logic        evtValid,
  input  logic [1:0]  evtKind,
  input  logic        evtLast,
  output logic        busy,
  output logic [1:0]  pidOut,
  output logic        dataToggle,
  output logic        doneValid,
  output logic        haltOut,
  output logic [31:0] ctlWordOut,
  output logic        carryOut,
  output logic        irqReq,
  output logic [2:0]  irqDelay
);

  td_strobe_t stb;
  logic [1:0] errCount;
  logic       rounding;
  logic       curToggle;

  td_ctrl #(
    .ERR_LIMIT  (ERR_LIMIT),
    .CC_XACT_ERR(CC_XACT_ERR),
    .CC_UNDERRUN(CC_UNDERRUN),
    .CC_BAD_PID (CC_BAD_PID)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .load     (load),
    .haltIn   (haltIn),
    .evtValid (evtValid),
    .evtKind  (evtKind),
    .evtLast  (evtLast),
    .errCount (errCount),
    .rounding (rounding),
    .pid      (pidOut),
    .stb      (stb),
    .busy     (busy),
    .doneValid(doneValid),
    .haltOut  (haltOut)
  );

  td_data i_data (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .ctlWordIn(ctlWordIn),
    .carryIn  (carryIn),
    .word     (ctlWordOut),
    .curToggle(curToggle),
    .errCount (errCount),
    .rounding (rounding),
    .pid      (pidOut)
  );

  assign dataToggle = curToggle;
  assign carryOut   = curToggle;
  assign irqDelay   = ctlWordOut[DLY_LO+2:DLY_LO];
  assign irqReq     = doneValid & ~haltOut & (irqDelay != 3'b111);

endmodule

// File: rtl/td_tracker_checker.sv
module td_tracker_checker (
  input logic        clk,
  input logic        rstN,
  input logic        load,
  input logic        haltIn,
  input logic        evtValid,
  input logic [1:0]  evtKind,
  input logic        busy,
  input logic [1:0]  pidOut,
  input logic        doneValid,
  input logic        haltOut,
  input logic [31:0] ctlWordOut,
  input logic        carryOut,
  input logic        irqReq
);

  a_r2_load_starts: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && load && !haltIn) |=> busy);

  a_r4_good_flips_carry: assert property (@(posedge clk) disable iff (!rstN)
    (busy && pidOut != 2'b11 && evtValid && evtKind == 2'b00)
      |=> carryOut != $past(carryOut));

  a_r8_bad_pid_retires: assert property (@(posedge clk) disable iff (!rstN)
    (busy && pidOut == 2'b11)
      |=> (doneValid && haltOut && ctlWordOut[31:28] == 4'b0111));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  a_r9_halt_with_done: assert property (@(posedge clk) disable iff (!rstN)
    haltOut |-> doneValid);

  a_r9_irq_clean_only: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (doneValid && !haltOut));

  a_r10_idle_word_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(load && !haltIn)) |=> $stable(ctlWordOut));

endmodule

bind td_completion_tracker td_tracker_checker i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .load      (load),
  .haltIn    (haltIn),
  .evtValid  (evtValid),
  .evtKind   (evtKind),
  .busy      (busy),
  .pidOut    (pidOut),
  .doneValid (doneValid),
  .haltOut   (haltOut),
  .ctlWordOut(ctlWordOut),
  .carryOut  (carryOut),
  .irqReq    (irqReq)
);

// File: tb/test_td_completion_tracker.sv
module test_td_completion_tracker;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [17:0] LOW = 18'h2ABCD;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        load = 1'b0;
  logic [31:0] ctlWordIn = '0;
  logic        carryIn = 1'b0;
  logic        haltIn = 1'b0;
  logic        evtValid = 1'b0;
  logic [1:0]  evtKind = 2'b11;
  logic        evtLast = 1'b0;
  logic        busy, dataToggle, doneValid, haltOut, carryOut, irqReq;
  logic [1:0]  pidOut;
  logic [31:0] ctlWordOut;
  logic [2:0]  irqDelay;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [31:0] word;
    logic        carry;
    logic        halt;
    logic        irq;
    logic [2:0]  delay;
    string       req;
  } item_t;

  item_t expQ[$];

  td_completion_tracker i_td_completion_tracker (
    .clk(clk), .rstN(rstN), .load(load), .ctlWordIn(ctlWordIn),
    .carryIn(carryIn), .haltIn(haltIn), .evtValid(evtValid),
    .evtKind(evtKind), .evtLast(evtLast), .busy(busy), .pidOut(pidOut),
    .dataToggle(dataToggle), .doneValid(doneValid), .haltOut(haltOut),
    .ctlWordOut(ctlWordOut), .carryOut(carryOut), .irqReq(irqReq),
    .irqDelay(irqDelay)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk(input logic [3:0] cc, input logic [1:0] ec,
      input logic [1:0] t, input logic [2:0] di, input logic [1:0] pid,
      input logic r);
    return {cc, ec, t, di, pid, r, LOW};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_done(input logic [31:0] w, input logic c, input logic h,
      input logic irq, input logic [2:0] d, input string req);
    item_t it;
    it.word = w; it.carry = c; it.halt = h; it.irq = irq; it.delay = d; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic loadTd(input logic [31:0] w, input logic c, input logic h);
    @(negedge clk);
    ctlWordIn = w; carryIn = c; haltIn = h; load = 1'b1;
    @(negedge clk);
    load = 1'b0; haltIn = 1'b0;
  endtask

  task automatic evt(input logic [1:0] k, input logic last);
    @(negedge clk);
    evtValid = 1'b1; evtKind = k; evtLast = last;
    @(negedge clk);
    evtValid = 1'b0; evtKind = 2'b11; evtLast = 1'b0;
  endtask

  // monitor: pops expected retire items
  always @(negedge clk) begin
    if (rstN && doneValid) begin
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 actual=unexpected retire expected=none");
      end else begin
        item_t it;
        it = expQ.pop_front();
        check(it.req, ctlWordOut, it.word);
        check(it.req, {31'd0, carryOut}, {31'd0, it.carry});
        check("R9", {31'd0, haltOut}, {31'd0, it.halt});
        check("R9", {31'd0, irqReq}, {31'd0, it.irq});
        if (it.irq) check("R9", {29'd0, irqDelay}, {29'd0, it.delay});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d cycles expected=end", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R1", {28'd0, busy, doneValid, haltOut, irqReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {28'd0, busy, doneValid, haltOut, irqReq}, 32'd0);

    // S1: toggle from carry, flips, error then clean completion (R3 R4 R6)
    expect_done(mk(4'h0, 2'd0, 2'b11, 3'd2, 2'b01, 1'b0), 1'b1, 1'b0, 1'b1, 3'd2, "R6");
    loadTd(mk(4'hF, 2'd0, 2'b00, 3'd2, 2'b01, 1'b0), 1'b1, 1'b0);
    check("R2", {31'd0, busy}, 32'd1);
    check("R3", {31'd0, dataToggle}, 32'd1);
    evt(2'b00, 1'b0);
    check("R4", {31'd0, dataToggle}, 32'd0);
    check("R4", {30'd0, ctlWordOut[25:24]}, 32'b10);
    evt(2'b01, 1'b0);
    check("R5", {30'd0, ctlWordOut[27:26]}, 32'd1);
    evt(2'b00, 1'b1);

    // S2: explicit toggle 0, three errors halt, delay 111 -> no irq (R3 R5)
    expect_done(mk(4'h1, 2'd3, 2'b10, 3'd7, 2'b10, 1'b0), 1'b0, 1'b1, 1'b0, 3'd7, "R5");
    loadTd(mk(4'hF, 2'd0, 2'b10, 3'd7, 2'b10, 1'b0), 1'b1, 1'b0);
    check("R3", {31'd0, dataToggle}, 32'd0);
    evt(2'b01, 1'b0);
    evt(2'b01, 1'b0);
    check("R5", {31'd0, busy}, 32'd1);
    evt(2'b01, 1'b0);
    check("R5", {31'd0, busy}, 32'd0);

    // S3: preloaded count 2, one error halts (R5)
    expect_done(mk(4'h1, 2'd3, 2'b11, 3'd1, 2'b00, 1'b1), 1'b1, 1'b1, 1'b0, 3'd1, "R5");
    loadTd(mk(4'hF, 2'd2, 2'b11, 3'd1, 2'b00, 1'b1), 1'b0, 1'b0);
    evt(2'b01, 1'b0);

    // S4: kind 11 ignored, then short with rounding -> clean (R10 R7)
    expect_done(mk(4'h0, 2'd0, 2'b11, 3'd3, 2'b10, 1'b1), 1'b1, 1'b0, 1'b1, 3'd3, "R7");
    loadTd(mk(4'hF, 2'd0, 2'b00, 3'd3, 2'b10, 1'b1), 1'b0, 1'b0);
    held = ctlWordOut;
    evt(2'b11, 1'b1);
    check("R10", ctlWordOut, held);
    check("R10", {30'd0, busy, dataToggle}, 32'b10);
    evt(2'b10, 1'b0);

    // S5: short without rounding -> underrun halt, count kept (R7)
    expect_done(mk(4'h9, 2'd1, 2'b10, 3'd4, 2'b10, 1'b0), 1'b0, 1'b1, 1'b0, 3'd4, "R7");
    loadTd(mk(4'hF, 2'd1, 2'b01, 3'd4, 2'b10, 1'b0), 1'b1, 1'b0);
    check("R3", {31'd0, dataToggle}, 32'd1);
    evt(2'b10, 1'b0);

    // S6: reserved PID retires without events (R8)
    expect_done(mk(4'h7, 2'd0, 2'b11, 3'd5, 2'b11, 1'b0), 1'b1, 1'b1, 1'b0, 3'd5, "R8");
    loadTd(mk(4'hF, 2'd0, 2'b11, 3'd5, 2'b11, 1'b0), 1'b0, 1'b0);
    @(negedge clk);
    check("R8", {31'd0, busy}, 32'd0);

    // S7: load refused while endpoint halted; idle events ignored (R2 R10)
    held = ctlWordOut;
    loadTd(mk(4'h0, 2'd0, 2'b00, 3'd0, 2'b01, 1'b0), 1'b1, 1'b1);
    check("R2", {31'd0, busy}, 32'd0);
    check("R2", ctlWordOut, held);
    evt(2'b00, 1'b1);
    evt(2'b01, 1'b0);
    check("R10", ctlWordOut, held);
    check("R10", {31'd0, busy}, 32'd0);

    repeat (3) @(negedge clk);
    check("R9", expQ.size(), 32'd0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule